// File: doc/BRIEF.md
# Two-Edge Source-Synchronous Burst Master Sequencer

This block acts as bus master for one block transfer on a VME-style backplane using the two-edge source-synchronous protocol. A DMA-style request supplies the start address, the block size in data words, an optional cap on the cycle count, a two-bit rate code, a broadcast enable and a 21-bit broadcast target mask. A separate configuration input sets how many clock cycles each strobe phase and each data edge is held.

When a request is accepted, the block runs three address phases on the address data strobe. In the first phase the strobe is asserted. In the second it is released. In the third it is asserted again. The data phase follows: a second strobe toggles once per data word, and no acknowledge is awaited from the receiver. The block then releases the bus for one cycle and pulses done. In broadcast mode the master acknowledges its own cycle. A retry seen from any slave during the third address phase aborts the attempt, and the transfer restarts from the first phase. Data words come from a FIFO-like source that is popped once per edge and is assumed never empty.

Top module: `sst_burst_master`

## Requirements
- R1: After reset, and after a reset applied in the middle of a transfer, `req_ready_o` is 1. All bus outputs (`as_o`, `ds0_o`, `am_o`, `addr_o`, `dstrb_o`, `data_o`, `dtack_o`) and `done_o`, `req_err_o` and `src_pop_o` are 0.
- R2: In the first address phase, starting the cycle after an accepted request and lasting `cfg_gap_i` cycles, `ds0_o`=1 and `as_o`=1, `am_o`=6'h20 and `addr_o` carries the start address.
- R3: In the second address phase (`cfg_gap_i` cycles), `ds0_o`=0 and `as_o`=1. `addr_o[1:0]` holds the rate code and `addr_o[9:2]` holds the cycle count; the other bits are 0. The cycle count is size/2, or the cap if the cap is nonzero and smaller than size/2.
- R4: In the third address phase (`cfg_gap_i` cycles), `ds0_o`=1. With broadcast, `addr_o[21:1]` holds the target mask and all other bits are 0. Without broadcast, `addr_o` is 0.
- R5: The data phase has 2×count edges, each held `cfg_gap_i` cycles. `dstrb_o` toggles from 0 at each edge, so it reads 1 on even-numbered edges (0, 2, …) and ends at 0. `data_o` carries successive source words, and exactly one `src_pop_o` is issued per edge.
- R6: `dtack_o` is 1 throughout the data phase when broadcast is enabled and is 0 otherwise.
- R7: If `retry_i` is 1 in any cycle of the third address phase, the bus is released for one cycle and the whole transfer restarts at the first phase with the same parameters. No data is sent by the aborted attempt.
- R8: Rate code encoding: 2'b00 = 160 class, 2'b01 = 267 class, 2'b10 = 320 class, 2'b11 = reserved. A request is refused if any of the following holds:
  - the rate code is 2'b11;
  - `cfg_gap_i` is below the minimum for the rate (4, 3 or 2 cycles, in the order above);
  - the size is odd;
  - the resulting count is 0.
  A refused request gives a one-cycle `req_err_o` pulse and no bus activity.
- R9: After the last edge, all bus lines are released for one cycle. Then `done_o` pulses for exactly one cycle, together with `req_ready_o` returning to 1.
- R10: A request presented while a transfer is in progress is ignored: no error flag is raised, and the transfer's timing and contents are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid_i | input | 1 | Transfer request |
| req_addr_i | input | ADDR_W | Start address |
| req_size_i | input | CNT_W+1 | Block size in data words |
| req_cap_i | input | CNT_W | Cycle count cap, 0 = none |
| req_rate_i | input | 2 | Rate code |
| req_bcast_i | input | 1 | Broadcast enable |
| req_mask_i | input | 21 | Broadcast target mask |
| cfg_gap_i | input | GAP_W | Cycles per phase and per data edge |
| req_ready_o | output | 1 | Idle, request can be taken |
| req_err_o | output | 1 | Request refused pulse |
| src_data_i | input | DATA_W | Head word of data source |
| src_pop_o | output | 1 | Pop data source |
| retry_i | input | 1 | Slave retry request |
| as_o | output | 1 | Address strobe, bus owned |
| ds0_o | output | 1 | Address data strobe |
| am_o | output | 6 | Address modifier |
| addr_o | output | ADDR_W | Address lines |
| dstrb_o | output | 1 | Data edge strobe |
| data_o | output | DATA_W | Data lines |
| dtack_o | output | 1 | Self-acknowledge in broadcast |
| done_o | output | 1 | Transfer complete pulse |

## Verification
The hardest case to reach from the ports is a retry that arrives inside the third address phase. The restart decision is taken only when that phase expires, so the retry must land in an exact cycle window. The bench computes that window from the programmed edge spacing and raises `retry_i` for a single cycle at its start. It then checks the release cycle and the complete second attempt, shifted by 3×gap+1 cycles. A second hard case is a request that arrives mid-transfer: the bench injects one carrying the reserved rate code during the second address phase and checks that no error appears and the transfer timing is unchanged.

// File: rtl/sst_pkg.sv
package sst_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADR1,
    ST_ADR2,
    ST_ADR3,
    ST_DATA,
    ST_REL
  } sst_state_e;

  localparam logic [5:0] AM_TWO_EDGE = 6'h20;
  localparam logic [1:0] RATE_160    = 2'b00;
  localparam logic [1:0] RATE_267    = 2'b01;
  localparam logic [1:0] RATE_320    = 2'b10;
  localparam logic [1:0] RATE_RSVD   = 2'b11;
endpackage

// File: rtl/sst_req_check.sv
module sst_req_check #(
  parameter int CNT_W       = 8,
  parameter int GAP_W       = 4,
  parameter int MIN_GAP_160 = 4,
  parameter int MIN_GAP_267 = 3,
  parameter int MIN_GAP_320 = 2
) (
  input  logic [CNT_W:0]   size_i,
  input  logic [CNT_W-1:0] cap_i,
  input  logic [1:0]       rate_i,
  input  logic [GAP_W-1:0] gap_i,
  output logic             ok_o,
  output logic [CNT_W-1:0] count_o
);
  import sst_pkg::*;

  localparam logic [GAP_W-1:0] MG_160 = GAP_W'(MIN_GAP_160);
  localparam logic [GAP_W-1:0] MG_267 = GAP_W'(MIN_GAP_267);
  localparam logic [GAP_W-1:0] MG_320 = GAP_W'(MIN_GAP_320);

  logic [CNT_W-1:0] half;
  logic [GAP_W-1:0] min_gap;

  always_comb begin
    half = size_i[CNT_W:1];
    if (cap_i != '0 && cap_i < half) count_o = cap_i;
    else                             count_o = half;
    unique case (rate_i)
      RATE_160: min_gap = MG_160;
      RATE_267: min_gap = MG_267;
      default:  min_gap = MG_320;
    endcase
    ok_o = (rate_i != RATE_RSVD) && (gap_i >= min_gap) &&
           !size_i[0] && (count_o != '0);
  end
endmodule

// File: rtl/sst_phase_timer.sv
module sst_phase_timer #(
  parameter int GAP_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [GAP_W-1:0] gap_i,
  input  logic             reload_i,
  output logic             expire_o
);
  logic [GAP_W-1:0] gap_q;
  logic [GAP_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap_q <= '0;
      cnt   <= '0;
    end else if (start_i) begin
      gap_q <= gap_i;
      cnt   <= gap_i - 1'b1;
    end else if (reload_i) begin
      cnt   <= gap_q - 1'b1;
    end else if (cnt != '0) begin
      cnt   <= cnt - 1'b1;
    end
  end

  assign expire_o = (cnt == '0);

  // R5: a phase or edge never lasts longer than the programmed spacing
  a_r5_cnt_in_window: assert property (@(posedge clk) disable iff (rst)
    (gap_q != '0) |-> (cnt < gap_q));
endmodule

// File: rtl/sst_edge_ctr.sv
module sst_edge_ctr #(
  parameter int CNT_W = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           clear_i,
  input  logic [CNT_W:0] total_i,
  input  logic           step_i,
  output logic           last_o
);
  logic [CNT_W:0] total_q;
  logic [CNT_W:0] idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      total_q <= '0;
      idx     <= '0;
    end else if (clear_i) begin
      total_q <= total_i;
      idx     <= '0;
    end else if (step_i) begin
      idx     <= idx + 1'b1;
    end
  end

  assign last_o = (idx == total_q - 1'b1);

  // R5: the edge index never runs past the edge total
  a_r5_idx_bound: assert property (@(posedge clk) disable iff (rst)
    (total_q != '0) |-> (idx < total_q));
endmodule

// File: rtl/sst_burst_master.sv
module sst_burst_master #(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int CNT_W       = 8,
  parameter int GAP_W       = 4,
  parameter int MIN_GAP_160 = 4,
  parameter int MIN_GAP_267 = 3,
  parameter int MIN_GAP_320 = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [CNT_W:0]    req_size_i,
  input  logic [CNT_W-1:0]  req_cap_i,
  input  logic [1:0]        req_rate_i,
  input  logic              req_bcast_i,
  input  logic [20:0]       req_mask_i,
  input  logic [GAP_W-1:0]  cfg_gap_i,
  output logic              req_ready_o,
  output logic              req_err_o,
  input  logic [DATA_W-1:0] src_data_i,
  output logic              src_pop_o,
  input  logic              retry_i,
  output logic              as_o,
  output logic              ds0_o,
  output logic [5:0]        am_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              dstrb_o,
  output logic [DATA_W-1:0] data_o,
  output logic              dtack_o,
  output logic              done_o
);
  import sst_pkg::*;

  localparam int EDGE_W = CNT_W + 1;

  sst_state_e       state, state_n;
  logic             req_ok;
  logic [CNT_W-1:0] req_count;
  logic             accept, reject;
  logic             expire, last_edge;
  logic             tmr_reload, edge_step, pop;
  logic             retry_seen;

  logic [ADDR_W-1:0] addr_q, f_addr;
  logic [CNT_W-1:0]  count_q, f_count;
  logic [1:0]        rate_q, f_rate;
  logic              bcast_q, f_bcast;
  logic [20:0]       mask_q, f_mask;

  sst_req_check #(
    .CNT_W(CNT_W), .GAP_W(GAP_W), .MIN_GAP_160(MIN_GAP_160),
    .MIN_GAP_267(MIN_GAP_267), .MIN_GAP_320(MIN_GAP_320)
  ) chk_i (
    .size_i(req_size_i), .cap_i(req_cap_i), .rate_i(req_rate_i),
    .gap_i(cfg_gap_i), .ok_o(req_ok), .count_o(req_count)
  );

  sst_phase_timer #(.GAP_W(GAP_W)) tmr_i (
    .clk(clk), .rst(rst), .start_i(accept), .gap_i(cfg_gap_i),
    .reload_i(tmr_reload), .expire_o(expire)
  );

  sst_edge_ctr #(.CNT_W(CNT_W)) edg_i (
    .clk(clk), .rst(rst), .clear_i(accept),
    .total_i(EDGE_W'({req_count, 1'b0})), .step_i(edge_step),
    .last_o(last_edge)
  );

  assign accept = (state == ST_IDLE) && req_valid_i && req_ok;
  assign reject = (state == ST_IDLE) && req_valid_i && !req_ok;

  // next state and phase sequencing
  always_comb begin
    state_n    = state;
    tmr_reload = 1'b0;
    edge_step  = 1'b0;
    pop        = 1'b0;
    unique case (state)
      ST_IDLE: if (accept) state_n = ST_ADR1;
      ST_ADR1: if (expire) begin state_n = ST_ADR2; tmr_reload = 1'b1; end
      ST_ADR2: if (expire) begin state_n = ST_ADR3; tmr_reload = 1'b1; end
      ST_ADR3: if (expire) begin
        if (retry_seen || retry_i) begin
          state_n = ST_REL;
        end else begin
          state_n    = ST_DATA;
          tmr_reload = 1'b1;
          pop        = 1'b1;
        end
      end
      ST_DATA: if (expire) begin
        if (last_edge) begin
          state_n = ST_REL;
        end else begin
          tmr_reload = 1'b1;
          edge_step  = 1'b1;
          pop        = 1'b1;
        end
      end
      ST_REL: begin
        state_n    = retry_seen ? ST_ADR1 : ST_IDLE;
        tmr_reload = retry_seen;
      end
      default: state_n = ST_IDLE;
    endcase
  end

  // field values as they will stand after this edge
  always_comb begin
    f_addr  = accept ? req_addr_i  : addr_q;
    f_count = accept ? req_count   : count_q;
    f_rate  = accept ? req_rate_i  : rate_q;
    f_bcast = accept ? req_bcast_i : bcast_q;
    f_mask  = accept ? req_mask_i  : mask_q;
  end

  assign src_pop_o = pop;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      addr_q     <= '0;
      count_q    <= '0;
      rate_q     <= '0;
      bcast_q    <= 1'b0;
      mask_q     <= '0;
      retry_seen <= 1'b0;
      req_ready_o <= 1'b1;
      req_err_o  <= 1'b0;
      as_o       <= 1'b0;
      ds0_o      <= 1'b0;
      am_o       <= '0;
      addr_o     <= '0;
      dstrb_o    <= 1'b0;
      data_o     <= '0;
      dtack_o    <= 1'b0;
      done_o     <= 1'b0;
    end else begin
      state   <= state_n;
      addr_q  <= f_addr;
      count_q <= f_count;
      rate_q  <= f_rate;
      bcast_q <= f_bcast;
      mask_q  <= f_mask;
      if (state == ST_REL)                 retry_seen <= 1'b0;
      else if (state == ST_ADR3 && retry_i) retry_seen <= 1'b1;

      req_ready_o <= (state_n == ST_IDLE);
      req_err_o   <= reject;
      done_o      <= (state == ST_REL) && !retry_seen;

      as_o  <= (state_n == ST_ADR1) || (state_n == ST_ADR2) ||
               (state_n == ST_ADR3) || (state_n == ST_DATA);
      ds0_o <= (state_n == ST_ADR1) || (state_n == ST_ADR3);
      am_o  <= (state_n == ST_IDLE || state_n == ST_REL) ? 6'h00 : AM_TWO_EDGE;

      unique case (state_n)
        ST_ADR1: addr_o <= f_addr;
        ST_ADR2: addr_o <= ADDR_W'({f_count, f_rate});
        ST_ADR3: addr_o <= f_bcast ? ADDR_W'({f_mask, 1'b0}) : '0;
        default: addr_o <= '0;
      endcase

      dtack_o <= (state_n == ST_DATA) && f_bcast;

      if (pop) begin
        dstrb_o <= ~dstrb_o;
        data_o  <= src_data_i;
      end else if (state_n != ST_DATA) begin
        data_o  <= '0;
      end
    end
  end

  // R9: done only with the bus released and the block ready again
  a_r9_done_released: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (!as_o && !ds0_o && !dstrb_o && req_ready_o));

  // R9: done is a single-cycle pulse
  a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R8: a refused request leaves the bus untouched
  a_r8_err_idle: assert property (@(posedge clk) disable iff (rst)
    req_err_o |-> (req_ready_o && !as_o));

  // R6: self-acknowledge only in a broadcast data phase
  a_r6_dtack_bcast: assert property (@(posedge clk) disable iff (rst)
    dtack_o |-> (as_o && !ds0_o && bcast_q));

  // R7: a retry at the end of phase three releases the bus next cycle
  a_r7_retry_release: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ADR3 && expire && retry_i) |=> (!as_o && !dstrb_o));

  // R10: a request while busy never raises the error flag
  a_r10_busy_ignored: assert property (@(posedge clk) disable iff (rst)
    (!req_ready_o && req_valid_i) |=> !req_err_o);
endmodule

// File: tb/sst_burst_master_tb_top.sv
module sst_burst_master_tb_top;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;
  localparam int CNT_W  = 8;
  localparam int GAP_W  = 4;

  typedef struct packed {
    logic [8:0]  size;
    logic [7:0]  cap;
    logic [1:0]  rate;
    logic [3:0]  gap;
    logic        bc;
    logic [20:0] mask;
    logic        rty;
    logic        poke;
    logic        ok;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{9'd8,  8'd0, 2'd0, 4'd4, 1'b0, 21'h0,      1'b0, 1'b0, 1'b1},
    '{9'd6,  8'd0, 2'd1, 4'd3, 1'b1, 21'h0A5A5,  1'b0, 1'b0, 1'b1},
    '{9'd10, 8'd2, 2'd2, 4'd2, 1'b0, 21'h0,      1'b0, 1'b0, 1'b1},
    '{9'd4,  8'd7, 2'd2, 4'd5, 1'b0, 21'h0,      1'b0, 1'b0, 1'b1},
    '{9'd4,  8'd0, 2'd0, 4'd4, 1'b1, 21'h100001, 1'b1, 1'b0, 1'b1},
    '{9'd6,  8'd0, 2'd1, 4'd3, 1'b0, 21'h0,      1'b0, 1'b1, 1'b1},
    '{9'd4,  8'd0, 2'd3, 4'd6, 1'b0, 21'h0,      1'b0, 1'b0, 1'b0},
    '{9'd4,  8'd0, 2'd0, 4'd3, 1'b0, 21'h0,      1'b0, 1'b0, 1'b0},
    '{9'd4,  8'd0, 2'd2, 4'd1, 1'b0, 21'h0,      1'b0, 1'b0, 1'b0},
    '{9'd0,  8'd0, 2'd0, 4'd4, 1'b0, 21'h0,      1'b0, 1'b0, 1'b0},
    '{9'd2,  8'd0, 2'd1, 4'd3, 1'b0, 21'h0,      1'b0, 1'b0, 1'b1},
    '{9'd5,  8'd0, 2'd1, 4'd3, 1'b0, 21'h0,      1'b0, 1'b0, 1'b0}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [CNT_W:0] req_size = '0;
  logic [CNT_W-1:0] req_cap = '0;
  logic [1:0] req_rate = '0;
  logic req_bcast = 1'b0;
  logic [20:0] req_mask = '0;
  logic [GAP_W-1:0] cfg_gap = 4'd4;
  logic retry = 1'b0;
  logic [DATA_W-1:0] src_data;
  logic req_ready, req_err, src_pop, as_s, ds0, dstrb, dtack, done;
  logic [5:0] am;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] data;

  int checks = 0;
  int failures = 0;
  int w = 0;
  logic w_clr = 1'b0;

  always #10 clk = ~clk;

  sst_burst_master dut_i (
    .clk(clk), .rst(rst), .req_valid_i(req_valid), .req_addr_i(req_addr),
    .req_size_i(req_size), .req_cap_i(req_cap), .req_rate_i(req_rate),
    .req_bcast_i(req_bcast), .req_mask_i(req_mask), .cfg_gap_i(cfg_gap),
    .req_ready_o(req_ready), .req_err_o(req_err), .src_data_i(src_data),
    .src_pop_o(src_pop), .retry_i(retry), .as_o(as_s), .ds0_o(ds0),
    .am_o(am), .addr_o(addr), .dstrb_o(dstrb), .data_o(data),
    .dtack_o(dtack), .done_o(done)
  );

  function automatic logic [31:0] pat(int k);
    return 32'h5A000000 + 32'(k) * 32'h00010003;
  endfunction

  always @(posedge clk) begin
    if (w_clr) w <= 0;
    else if (src_pop) w <= w + 1;
  end
  assign src_data = pat(w);

  task automatic chk(bit cond, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!cond) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle_check(string tag);
    chk(req_ready && !as_s && !ds0 && am == 6'h0 && addr == '0 && !dstrb &&
        data == '0 && !dtack && !done && !req_err && !src_pop,
        tag, {26'h0, req_ready, as_s, ds0, dstrb, dtack, done}, 32'h20);
  endtask

  task automatic phase_check(int cc, int g, logic [31:0] start,
                             logic [31:0] ph2, logic [31:0] ph3);
    if (cc < g)
      chk(ds0 && as_s && am == 6'h20 && addr == start, "R2 phase1", addr, start);
    else if (cc < 2 * g)
      chk(!ds0 && as_s && am == 6'h20 && addr == ph2, "R3 phase2", addr, ph2);
    else
      chk(ds0 && as_s && addr == ph3, "R4 phase3", addr, ph3);
  endtask

  task automatic run_vec(vec_t v, int idx);
    logic [31:0] start, ph2, ph3;
    int g, cnt, off, tend, k;
    start = 32'h1000_0000 + 32'(idx) * 32'h100;
    g = int'(v.gap);
    cnt = int'(v.size) / 2;
    if (v.cap != 0 && int'(v.cap) < cnt) cnt = int'(v.cap);
    ph2 = (32'(cnt) << 2) | 32'(v.rate);
    ph3 = v.bc ? (32'(v.mask) << 1) : 32'h0;
    off = v.rty ? 3 * g + 1 : 0;
    tend = off + 3 * g + 2 * cnt * g + 1;

    @(negedge clk);
    w_clr = 1'b1;
    req_addr = start; req_size = v.size; req_cap = v.cap; req_rate = v.rate;
    req_bcast = v.bc; req_mask = v.mask; cfg_gap = v.gap; req_valid = 1'b1;

    if (!v.ok) begin
      for (int c = 0; c < 6; c++) begin
        @(negedge clk);
        req_valid = 1'b0; w_clr = 1'b0;
        chk(req_err == (c == 0), "R8 err pulse", {31'h0, req_err}, {31'h0, c == 0});
        chk(!as_s && !ds0 && req_ready, "R8 no bus activity", {31'h0, as_s}, 32'h0);
      end
      return;
    end

    for (int c = 0; c <= tend + 1; c++) begin
      @(negedge clk);
      w_clr = 1'b0;
      req_valid = v.poke && (c == g + 1);
      req_rate = req_valid ? 2'd3 : v.rate;
      retry = v.rty && (c == 2 * g);
      chk(!req_err, "R10 no error while busy", {31'h0, req_err}, 32'h0);
      chk(done == (c == tend), "R9 done timing", {31'h0, done}, {31'h0, c == tend});
      if (c < off) begin
        if (c < 3 * g) phase_check(c, g, start, ph2, ph3);
        else chk(!as_s && !ds0 && !dstrb && w == 0, "R7 retry release",
                 {31'h0, as_s}, 32'h0);
      end else begin
        int cc;
        cc = c - off;
        if (cc < 3 * g) begin
          phase_check(cc, g, start, ph2, ph3);
        end else if (cc < 3 * g + 2 * cnt * g) begin
          k = (cc - 3 * g) / g;
          chk(data == pat(k) && !ds0 && as_s, "R5 data word", data, pat(k));
          chk(dstrb == (k % 2 == 0), "R5 strobe level", {31'h0, dstrb}, {31'h0, k % 2 == 0});
          chk(dtack == v.bc, "R6 dtack", {31'h0, dtack}, {31'h0, v.bc});
        end else if (cc == 3 * g + 2 * cnt * g) begin
          chk(!as_s && !ds0 && !dstrb && !dtack && !done, "R9 release cycle",
              {31'h0, as_s}, 32'h0);
        end else if (c == tend) begin
          chk(req_ready, "R9 ready with done", {31'h0, req_ready}, 32'h1);
          chk(w == 2 * cnt, "R5 pop count", 32'(w), 32'(2 * cnt));
        end
      end
    end
    req_valid = 1'b0;
    req_rate = v.rate;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 100000, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    idle_check("R1 reset state");

    for (int i = 0; i < NV; i++) begin
      run_vec(VECS[i], i);
      repeat (2) @(negedge clk);
      idle_check("R1 idle between transfers");
    end

    // R1: reset in the middle of a data phase releases the bus
    @(negedge clk);
    req_addr = 32'h2000_0000; req_size = 9'd8; req_cap = '0; req_rate = 2'd2;
    req_bcast = 1'b1; req_mask = 21'h1; cfg_gap = 4'd2; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (8) @(negedge clk);
    chk(as_s && dtack, "R1 transfer active before reset", {31'h0, as_s}, 32'h1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    idle_check("R1 reset mid transfer");
    @(negedge clk);
    idle_check("R1 stays idle after reset");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule